// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a set of asynchronous external lines and turns their transitions into interrupt events. Software picks a detection mode for each line: rising edges, falling edges, or both. A selected edge sets a sticky pending flag for that line. Software clears the flag by writing a one to it.

A per-line interrupt enable does not gate the pending flag. It only decides whether the edge also produces a one-clock pulse on that line's interrupt output. Two further registers hold an event enable and a software-trigger word. They are plain storage for neighbouring logic.

All configuration and servicing goes through a 32-bit register bus. The bus has single-cycle writes and a combinational read port, and it decodes a 1 KiB window.

Top module: `eirq_ctrl`

## Requirements
- R1: After reset, every register reads zero and no interrupt output is high.
- R2: A low-to-high change on line i sets pending bit i only when bit i of the rising-select register (offset 0x08) is 1.
- R3: A high-to-low change on line i sets pending bit i only when bit i of the falling-select register (offset 0x0C) is 1.
- R4: With both select bits of a line set, either direction of change sets that line's pending bit.
- R5: A selected edge sets its pending bit even when the line's interrupt-enable bit (register at offset 0x00) is 0, and in that case no pulse appears on that line's output.
- R6: When a selected edge occurs on a line whose interrupt-enable bit is 1, that line's output is high for exactly one clock. The pulse and the pending bit appear on the third rising clock edge after the input changes: two for synchronisation and one for detection.
- R7: A write to the pending register (offset 0x14) clears each bit written as 1 and leaves bits written as 0 unchanged. Pending bits fall by no other means outside reset.
- R8: The interrupt-enable (0x00), event-enable (0x04), rising-select, falling-select and software-trigger (0x10) registers return the last value written. Bits at and above the line count read as zero.
- R9: Reads of any other offset in the window return zero, and writes to them change no register. Decoding is by exact byte offset, so unaligned offsets are unmapped.
- R10: When an edge sets a pending bit on the same clock as a write that clears it, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_in | input | LINES | Asynchronous external interrupt lines |
| bus_addr | input | ADDR_W | Byte offset within the register window |
| bus_wr | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_pulse | output | LINES | Per-line one-clock interrupt pulses |

## Verification
The one-clock pulse property depends on an input assumption. After each change, an external line must hold its new level for at least two clocks, so that detected edges on one line never fall on neighbouring cycles. The properties also assume reset is asserted from time zero.

The bench respects both assumptions. It changes the lines only on falling clock edges, and it waits at least four clocks between changes. Each change is a single step per vector, so every line holds its level far longer than two clocks.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  localparam int unsigned REG_W = 32;

  // byte offsets of the register file
  localparam logic [REG_W-1:0] OFF_MASK   = 32'h0000_0000;
  localparam logic [REG_W-1:0] OFF_EVMASK = 32'h0000_0004;
  localparam logic [REG_W-1:0] OFF_RISE   = 32'h0000_0008;
  localparam logic [REG_W-1:0] OFF_FALL   = 32'h0000_000C;
  localparam logic [REG_W-1:0] OFF_SWTRIG = 32'h0000_0010;
  localparam logic [REG_W-1:0] OFF_PEND   = 32'h0000_0014;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_EVMASK,
    SEL_RISE,
    SEL_FALL,
    SEL_SWTRIG,
    SEL_PEND
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [REG_W-1:0] off);
    reg_sel_e s;
    case (off)
      OFF_MASK:   s = SEL_MASK;
      OFF_EVMASK: s = SEL_EVMASK;
      OFF_RISE:   s = SEL_RISE;
      OFF_FALL:   s = SEL_FALL;
      OFF_SWTRIG: s = SEL_SWTRIG;
      OFF_PEND:   s = SEL_PEND;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int unsigned LINES  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);

  for (genvar gl = 0; gl < LINES; gl++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], din[gl]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_d;
      end
    end

    assign dout[gl] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/eirq_edge.sv
module eirq_edge #(
  parameter int unsigned LINES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] sync_in,
  input  logic [LINES-1:0] rise_sel,
  input  logic [LINES-1:0] fall_sel,
  input  logic [LINES-1:0] int_mask,
  output logic [LINES-1:0] hit,
  output logic [LINES-1:0] pulse
);

  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] pulse_q;
  logic [LINES-1:0] rise_w;
  logic [LINES-1:0] fall_w;
  logic [LINES-1:0] pulse_d;

  // compare the synchronised level with last cycle's copy
  always_comb begin
    rise_w  = sync_in & ~prev_q;
    fall_w  = ~sync_in & prev_q;
    hit     = (rise_w & rise_sel) | (fall_w & fall_sel);
    pulse_d = hit & int_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      pulse_q <= '0;
    end else begin
      prev_q  <= sync_in;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int unsigned LINES  = 16,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [LINES-1:0]  hit,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [LINES-1:0]  int_mask,
  output logic [LINES-1:0]  rise_sel,
  output logic [LINES-1:0]  fall_sel,
  output logic [LINES-1:0]  pend
);

  reg_sel_e         sel;
  logic [LINES-1:0] wval;
  logic             unused_wdata;

  logic [LINES-1:0] mask_q, evmask_q, rise_q, fall_q, swtrig_q, pend_q;
  logic [LINES-1:0] pend_d;
  logic             en_mask, en_evmask, en_rise, en_fall, en_swtrig;
  logic [LINES-1:0] clr_vec;

  assign unused_wdata = ^bus_wdata;

  // decode and next-state
  always_comb begin
    sel       = decode_off(REG_W'(bus_addr));
    wval      = bus_wdata[LINES-1:0];
    en_mask   = bus_wr && (sel == SEL_MASK);
    en_evmask = bus_wr && (sel == SEL_EVMASK);
    en_rise   = bus_wr && (sel == SEL_RISE);
    en_fall   = bus_wr && (sel == SEL_FALL);
    en_swtrig = bus_wr && (sel == SEL_SWTRIG);
    clr_vec   = (bus_wr && (sel == SEL_PEND)) ? wval : '0;
    // a new edge outranks a clear in the same cycle
    pend_d    = (pend_q & ~clr_vec) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      evmask_q <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
      swtrig_q <= '0;
      pend_q   <= '0;
    end else begin
      if (en_mask)   mask_q   <= wval;
      if (en_evmask) evmask_q <= wval;
      if (en_rise)   rise_q   <= wval;
      if (en_fall)   fall_q   <= wval;
      if (en_swtrig) swtrig_q <= wval;
      pend_q <= pend_d;
    end
  end

  // read mux, upper bits zero-extended
  always_comb begin
    unique case (sel)
      SEL_MASK:   bus_rdata = REG_W'(mask_q);
      SEL_EVMASK: bus_rdata = REG_W'(evmask_q);
      SEL_RISE:   bus_rdata = REG_W'(rise_q);
      SEL_FALL:   bus_rdata = REG_W'(fall_q);
      SEL_SWTRIG: bus_rdata = REG_W'(swtrig_q);
      SEL_PEND:   bus_rdata = REG_W'(pend_q);
      default:    bus_rdata = '0;
    endcase
  end

  assign int_mask = mask_q;
  assign rise_sel = rise_q;
  assign fall_sel = fall_q;
  assign pend     = pend_q;

endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
  import eirq_pkg::*;
#(
  parameter int unsigned LINES       = 16,
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  ext_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [LINES-1:0]  irq_pulse
);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic [LINES-1:0] sync_w;
  logic [LINES-1:0] hit_w;
  logic [LINES-1:0] imr_w;
  logic [LINES-1:0] rise_w;
  logic [LINES-1:0] fall_w;
  logic [LINES-1:0] pend_w;

  // reset asserts at once, deasserts on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  eirq_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (ext_in),
    .dout  (sync_w)
  );

  eirq_edge #(.LINES(LINES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sync_in  (sync_w),
    .rise_sel (rise_w),
    .fall_sel (fall_w),
    .int_mask (imr_w),
    .hit      (hit_w),
    .pulse    (irq_pulse)
  );

  eirq_regs #(.LINES(LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .hit       (hit_w),
    .bus_rdata (bus_rdata),
    .int_mask  (imr_w),
    .rise_sel  (rise_w),
    .fall_sel  (fall_w),
    .pend      (pend_w)
  );

endmodule

// File: rtl/eirq_ctrl_chk.sv
module eirq_ctrl_chk
  import eirq_pkg::*;
#(
  parameter int unsigned LINES  = 16,
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic [LINES-1:0]  irq_pulse,
  input logic [LINES-1:0]  pend,
  input logic [LINES-1:0]  imr
);

  localparam logic [REG_W-1:0] LMASK = REG_W'((64'd1 << LINES) - 64'd1);

  logic [LINES-1:0] clr_req;
  logic             mapped;
  logic             unused_chk;

  assign unused_chk = ^bus_wdata;

  always_comb begin
    mapped  = decode_off(REG_W'(bus_addr)) != SEL_NONE;
    clr_req = (bus_wr && (REG_W'(bus_addr) == OFF_PEND)) ? bus_wdata[LINES-1:0] : '0;
  end

  // R6
  pulse_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse & $past(irq_pulse)) == '0);

  // R5
  pulse_has_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse & ~pend) == '0);

  // R6
  pulse_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse & ~$past(imr)) == '0);

  // R7
  pend_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend) & ~pend & ~$past(clr_req)) == '0);

  // R8
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~LMASK) == '0);

  // R9
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> bus_rdata == '0);

endmodule

bind eirq_ctrl eirq_ctrl_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_pulse (irq_pulse),
  .pend      (pend_w),
  .imr       (imr_w)
);

// File: tb/tb_eirq_ctrl.sv
module tb_eirq_ctrl;

  localparam int unsigned LINES  = 16;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned NVEC   = 6;

  // each vector: {rise_sel, fall_sel, mask, new_ext, exp_pend, exp_pulse}
  localparam logic [95:0] VECS [NVEC] = '{
    {16'h00FF, 16'h0000, 16'h000F, 16'h0F0F, 16'h000F, 16'h000F},
    {16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 16'h0F0F, 16'h0000},
    {16'hF0F0, 16'h0000, 16'hFFFF, 16'h00FF, 16'h00F0, 16'h00F0},
    {16'hFFFF, 16'hFFFF, 16'h0F0F, 16'hFF00, 16'hFFFF, 16'h0F0F},
    {16'h0000, 16'h00FF, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000},
    {16'hFF00, 16'h0F00, 16'h0300, 16'h0000, 16'h0F00, 16'h0300}
  };

  logic              clk;
  logic              rst_n;
  logic [LINES-1:0]  ext_in;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_wr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [LINES-1:0]  irq_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  eirq_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_in    (ext_in),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_pulse (irq_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    tick();
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic string vtag(input int i);
    case (i)
      1:       return "R5";
      3:       return "R4";
      5:       return "R3";
      default: return "R2";
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    rst_n     = 1'b0;
    ext_in    = '0;
    bus_addr  = '0;
    bus_wr    = 1'b0;
    bus_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(ADDR_W'(a * 4), rv);
      chk("R1 register reset", rv, 32'h0);
    end
    chk("R1 outputs idle", 32'(irq_pulse), 32'h0);

    // vector walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      logic [95:0] v;
      v = VECS[i];
      wr(10'h014, 32'hFFFF);
      wr(10'h008, 32'(v[95:80]));
      wr(10'h00C, 32'(v[79:64]));
      wr(10'h000, 32'(v[63:48]));
      ext_in = v[47:32];
      tick();
      tick();
      chk("R6 no pulse before third edge", 32'(irq_pulse), 32'h0);
      tick();
      chk({vtag(i), " R6 pulse"}, 32'(irq_pulse), 32'(v[15:0]));
      rd(10'h014, rv);
      chk({vtag(i), " pending"}, rv, 32'(v[31:16]));
      tick();
      chk("R6 pulse lasts one cycle", 32'(irq_pulse), 32'h0);
    end

    // R7: write-one-to-clear on pending = 0F00
    wr(10'h014, 32'h0100);
    rd(10'h014, rv);
    chk("R7 clear written ones", rv, 32'h0E00);
    wr(10'h014, 32'h0);
    rd(10'h014, rv);
    chk("R7 zeros leave bits", rv, 32'h0E00);

    // R10: set wins over clear in the same cycle
    wr(10'h014, 32'hFFFF);
    wr(10'h008, 32'h0001);
    wr(10'h000, 32'h0001);
    ext_in = 16'h0001;
    tick();
    tick();
    bus_addr  = 10'h014;
    bus_wdata = 32'h1;
    bus_wr    = 1'b1;
    tick();
    bus_wr    = 1'b0;
    chk("R10 pulse with collision", 32'(irq_pulse), 32'h1);
    rd(10'h014, rv);
    chk("R10 set wins", rv, 32'h1);

    // R8: storage and upper bits
    wr(10'h000, 32'hFFFF_FFFF);
    rd(10'h000, rv);
    chk("R8 mask upper zero", rv, 32'h0000_FFFF);
    wr(10'h010, 32'hA5A5_1234);
    rd(10'h010, rv);
    chk("R8 software word", rv, 32'h0000_1234);
    wr(10'h004, 32'h0000_BEEF);
    rd(10'h004, rv);
    chk("R8 event mask", rv, 32'h0000_BEEF);
    rd(10'h008, rv);
    chk("R8 rising select", rv, 32'h0000_0001);

    // R9: unmapped offsets
    wr(10'h018, 32'hFFFF_FFFF);
    rd(10'h018, rv);
    chk("R9 unmapped read", rv, 32'h0);
    rd(10'h004, rv);
    chk("R9 event mask untouched", rv, 32'h0000_BEEF);
    wr(10'h001, 32'h0);
    rd(10'h000, rv);
    chk("R9 unaligned write ignored", rv, 32'h0000_FFFF);
    rd(10'h3FC, rv);
    chk("R9 top of window", rv, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule